// File: doc/BRIEF.md
# I2C Target Register Bank

This block is an I2C target that owns a small bank of ten 8-bit control registers. A faster system clock oversamples the bus: SCL and SDA pass through synchronizers and edge detectors, a bit-level state machine follows the protocol, and SDA is pulled low only through an open-drain output enable. A host writes one register or a run of registers by sending the device address, a register-address byte and then data. It reads by a current-address read or by a random read.

A random read is a short write that carries only the register address, followed by a repeated START and a read. One internal address counter holds its value between transactions. It advances after every data byte in either direction and wraps from the last register back to register zero. Clock stretching, 10-bit addressing and general call are not supported.

Top module: `i2c_regbank_target`

## Requirements
- R1: After the asynchronous active-low reset, SDA is released (`sda_oe_o` low), every register reads 0 and the address counter is 0.
- R2: A 7-bit device address equal to parameter `DEV_ADDR`, sent in bits 7..1 of the first byte after START, is acknowledged by pulling SDA low during the ninth SCL pulse. Bit 0 is the R/W flag, with 1 meaning read. Any other address gets no acknowledge. The block then acknowledges nothing and changes no register until the next START.
- R3: In a write, the byte that follows the device address loads its low five bits into the address counter and is always acknowledged, including values above 09h.
- R4: Each further byte of a write is stored at the counter's address and acknowledged. The counter then advances.
- R5: A read that starts directly with the device address and R/W=1 returns the register at the counter. Because the counter persists, the first byte returned is the register after the last one accessed.
- R6: A write of device address and register address, followed by a repeated START and the device address with R/W=1, returns data starting at that register address.
- R7: While the host acknowledges each read byte, the block sends the following registers. After a byte that the host does not acknowledge, SDA stays released.
- R8: When the counter advances from 09h, or from any value above 09h, it goes to 00h. This applies to reads and to writes.
- R9: Register addresses above 09h read as 00h and ignore writes.
- R10: `sda_oe_o` changes only while the synchronized SCL is low, or when a START or STOP is detected.
- R11: START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) are recognized in any state. A byte cut short by either of them is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (resolved wired-AND level) |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low; when low, SDA is released |

## Verification
The hardest situations to reach are the ones where the host abandons a transfer partway through. A STOP can arrive in the middle of a data byte, or a repeated START can land after only a few bits. Neither may leave a half-received byte in a register. The bench reaches these with a host task that clocks out only part of a byte before it issues the condition. It then reads the target register back over the bus. The counter wrap is reached the same way, from register 09h and from an out-of-range address.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

  // Protocol phases of the target state machine
  typedef enum logic [3:0] {
    ST_IDLE,     // bus free, waiting for START
    ST_DEV,      // shifting in device address + R/W
    ST_DEV_ACK,  // driving ACK for device address
    ST_REG,      // shifting in register-address byte
    ST_REG_ACK,  // driving ACK for register address
    ST_WR,       // shifting in write data
    ST_WR_ACK,   // driving ACK for write data
    ST_RD,       // shifting out read data
    ST_RD_MACK,  // host acknowledge slot after read byte
    ST_IGNORE    // not addressed / read ended, wait for START or STOP
  } tgt_state_e;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_sh_q, sda_sh_q;
  logic              scl_d_q, sda_d_q;

  // Idle bus level is high, so all stages reset to one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
      sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
      scl_d_q  <= scl_sh_q[STAGES-1];
      sda_d_q  <= sda_sh_q[STAGES-1];
    end
  end

  always_comb begin
    scl_o      = scl_sh_q[STAGES-1];
    sda_o      = sda_sh_q[STAGES-1];
    scl_rise_o = scl_o & ~scl_d_q;
    scl_fall_o = ~scl_o & scl_d_q;
    start_o    = scl_o & scl_d_q & sda_d_q & ~sda_o;
    stop_o     = scl_o & scl_d_q & ~sda_d_q & sda_o;
  end

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
  parameter int NUM_REGS = 10,
  parameter int DATA_W   = 8,
  parameter int AW       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic wen;
    assign wen = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (wen) regs_q[g] <= wdata;
    end
  end

  // Unmapped addresses read as zero
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (raddr == AW'(i)) rdata = regs_q[i];
  end

  AST_OOR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr >= AW'(NUM_REGS)) |=> $stable(regs_q)) else $error("oor write"); // R9
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr >= AW'(NUM_REGS)) |-> (rdata == '0)) else $error("oor read"); // R9

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NUM_REGS = 10,
  parameter int         DATA_W   = 8,
  parameter int         AW       = 6,
  parameter int         RA_BITS  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int            BCW  = $clog2(DATA_W + 1);
  localparam logic [AW-1:0] LAST = AW'(NUM_REGS - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_rb_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tgt_state_e        state_q, state_d;
  logic [BCW-1:0]    bitcnt_q, bitcnt_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [AW-1:0]     ptr_q, ptr_d, ptr_next;
  logic              rw_q, rw_d, mack_q, mack_d, oe_q, oe_d;
  logic              reg_we;
  logic [DATA_W-1:0] reg_rdata;

  i2c_rb_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(ptr_q), .wdata(shreg_q),
    .raddr(ptr_q), .rdata(reg_rdata)
  );

  // Counter advance: anything at or above the last register wraps to zero
  assign ptr_next = (ptr_q >= LAST) ? '0 : ptr_q + AW'(1);

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    ptr_d    = ptr_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    oe_d     = oe_q;
    reg_we   = 1'b0;
    if (stop_det) begin
      state_d  = ST_IDLE;
      oe_d     = 1'b0;
      bitcnt_d = '0;
    end else if (start_det) begin
      state_d  = ST_DEV;
      oe_d     = 1'b0;
      bitcnt_d = '0;
    end else begin
      case (state_q)
        ST_DEV, ST_REG, ST_WR: begin
          if (scl_rise) begin
            shreg_d  = {shreg_q[DATA_W-2:0], sda_s};
            bitcnt_d = bitcnt_q + BCW'(1);
          end else if (scl_fall && bitcnt_q == BCW'(DATA_W)) begin
            bitcnt_d = '0;
            if (state_q == ST_DEV) begin
              if (shreg_q[DATA_W-1:1] == DEV_ADDR) begin
                rw_d    = shreg_q[0];
                oe_d    = 1'b1;
                state_d = ST_DEV_ACK;
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_REG) begin
              ptr_d   = AW'(shreg_q[RA_BITS-1:0]);
              oe_d    = 1'b1;
              state_d = ST_REG_ACK;
            end else begin
              reg_we  = 1'b1;
              ptr_d   = ptr_next;
              oe_d    = 1'b1;
              state_d = ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK, ST_RD_MACK: begin
          if (state_q == ST_RD_MACK && scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if ((state_q == ST_DEV_ACK && rw_q) || (state_q == ST_RD_MACK && mack_q)) begin
              shreg_d  = reg_rdata;
              oe_d     = ~reg_rdata[DATA_W-1];
              ptr_d    = ptr_next;
              bitcnt_d = '0;
              state_d  = ST_RD;
            end else begin
              oe_d    = 1'b0;
              state_d = (state_q == ST_DEV_ACK) ? ST_REG : ST_IGNORE;
            end
          end
        end
        ST_REG_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt_q == BCW'(DATA_W - 1)) begin
              oe_d     = 1'b0;
              bitcnt_d = '0;
              state_d  = ST_RD_MACK;
            end else begin
              shreg_d  = shreg_q << 1;
              oe_d     = ~shreg_q[DATA_W-2];
              bitcnt_d = bitcnt_q + BCW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      rw_q     <= rw_d;
      mack_q   <= mack_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;

  AST_OE_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)))
    else $error("oe moved with scl high"); // R10
  AST_RELEASED_WHEN_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !oe_q) else $error("driving while idle"); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ptr_q == LAST) |=> (ptr_q == '0)) else $error("no wrap"); // R8
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REG_ACK && $past(state_q) == ST_REG) |-> (ptr_q == AW'($past(shreg_q[RA_BITS-1:0]))))
    else $error("bad ptr load"); // R3

endmodule

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;

  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 10;

  logic clk, rst_n, scl_m, sda_m, sda_oe;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_regbank_target #(.DEV_ADDR(DEV)) i_i2c_regbank_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, r10_bad = 0;
  bit mon_en = 1'b0;
  logic [7:0] exp_val[$];
  string      exp_tag[$];
  logic [7:0] mreg [32];
  int         mptr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  // Reference model of the counter and registers
  task automatic m_adv();
    mptr = (mptr >= 9) ? 0 : mptr + 1;
  endtask

  task automatic push_read(input string tag);
    exp_val.push_back((mptr < 10) ? mreg[mptr] : 8'h00);
    exp_tag.push_back(tag);
    m_adv();
  endtask

  // Bus-level driver
  task automatic i2c_start();
    sda_m = 1; scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask
  task automatic i2c_rstart();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask
  task automatic i2c_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq();
  endtask
  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(); scl_m = 0; wq();
    end
  endtask
  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; wq(); scl_m = 1; wq(); ack = ~sda_bus; scl_m = 0; wq();
  endtask
  task automatic recv_byte(input bit mack, input string tag);
    sda_m = 1; mon_en = 1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl_m = 1; wq(); scl_m = 0;
    end
    wq(); mon_en = 0; sda_m = ~mack; wq(); scl_m = 1; wq();
    if (!mack) chk(sda_bus == 1'b1, {tag, " R7 SDA released at NACK"}, sda_bus, 1);
    scl_m = 0; wq(); sda_m = 1;
  endtask

  task automatic wr_seq(input logic [4:0] ra, input int n, input logic [31:0] dw, input string tag);
    bit ack;
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2 dev ack", ack, 1);
    send_byte({3'b000, ra}, ack); chk(ack, "R3 reg addr ack", ack, 1);
    mptr = int'(ra);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = dw[31-8*i -: 8];
      send_byte(b, ack); chk(ack, {tag, " R4 data ack"}, ack, 1);
      if (mptr < 10) mreg[mptr] = b;
      m_adv();
    end
    i2c_stop();
  endtask

  task automatic rd_cur(input int n, input string tag);
    bit ack;
    i2c_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, {tag, " R5 dev ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      push_read(tag);
      recv_byte(i < n - 1, tag);
    end
    i2c_stop();
  endtask

  task automatic rd_rand(input logic [4:0] ra, input int n, input string tag);
    bit ack;
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2 dev ack", ack, 1);
    send_byte({3'b000, ra}, ack); chk(ack, "R3 reg addr ack", ack, 1);
    mptr = int'(ra);
    i2c_rstart();
    send_byte({DEV, 1'b1}, ack); chk(ack, {tag, " R6 dev ack after rstart"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      push_read(tag);
      recv_byte(i < n - 1, tag);
    end
    i2c_stop();
  endtask

  // Scoreboard monitor: assembles read bytes at SCL rising edges
  initial begin
    logic [7:0] sh;
    int n;
    n = 0;
    forever begin
      @(posedge scl_m);
      if (mon_en) begin
        sh = {sh[6:0], sda_bus};
        n++;
        if (n == 8) begin
          n = 0;
          if (exp_val.size() == 0) chk(1'b0, "R5 unexpected read byte", sh, 0);
          else begin
            logic [7:0] ev;
            string et;
            ev = exp_val.pop_front();
            et = exp_tag.pop_front();
            chk(sh == ev, {et, " read data"}, sh, ev);
          end
        end
      end
    end
  end

  // R10 observer: output enable must not move during a settled SCL-high phase
  initial begin
    int hi;
    logic prev;
    hi = 0; prev = 1'b0;
    forever begin
      @(negedge clk);
      hi = scl_m ? hi + 1 : 0;
      if (rst_n && hi >= 6 && sda_oe != prev) r10_bad++;
      prev = sda_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
    mptr = 0;
    rst_n = 0; scl_m = 1; sda_m = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);

    rd_cur(2, "R1");                          // regs 0,1 read zero, counter starts at 0
    wr_seq(5'd3, 4, 32'hA1B2C3D4, "R4");      // regs 3..6
    rd_rand(5'd3, 2, "R6");                   // 3,4 -> counter 5
    rd_cur(2, "R5");                          // 5,6 continue from counter
    wr_seq(5'd2, 1, 32'hE2000000, "R4");      // counter -> 3
    rd_cur(1, "R5");                          // reg 3 after write to reg 2
    wr_seq(5'd8, 3, 32'h11223300, "R8");      // 8,9 then wrap to 0
    rd_rand(5'd8, 4, "R8");                   // 8,9,0,1 with wrap
    wr_seq(5'h15, 1, 32'h55000000, "R9");     // out-of-range write ignored
    rd_rand(5'h15, 2, "R9");                  // reads 0, then wraps to reg 0 (R8)

    // R2: wrong device address: no ACK, later bytes not acknowledged or stored
    i2c_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack); chk(!ack, "R2 mismatched address not acked", ack, 0);
    send_byte(8'h02, ack); chk(!ack, "R2 ignored byte not acked", ack, 0);
    send_byte(8'hFF, ack); chk(!ack, "R2 ignored byte not acked", ack, 0);
    i2c_stop();
    rd_rand(5'd2, 1, "R2");

    // R11: STOP in the middle of a data byte discards it
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R11 dev ack", ack, 1);
    send_byte(8'h04, ack); chk(ack, "R11 reg ack", ack, 1);
    send_bits(8'h0F, 4);
    i2c_stop();
    rd_rand(5'd4, 1, "R11");

    // R11: repeated START after three bits restarts address phase
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R11 dev ack", ack, 1);
    send_bits(8'h5A, 3);
    i2c_rstart();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R11 dev ack after restart", ack, 1);
    send_byte(8'h07, ack); chk(ack, "R11 reg ack after restart", ack, 1);
    send_byte(8'h77, ack); chk(ack, "R11 data ack after restart", ack, 1);
    mreg[7] = 8'h77; mptr = 8;
    i2c_stop();
    rd_rand(5'd7, 1, "R11");

    wq();
    chk(exp_val.size() == 0, "R7 all expected bytes seen", exp_val.size(), 0);
    chk(r10_bad == 0, "R10 oe steady while SCL high", r10_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule